// File: doc/BRIEF.md
# Banked Video Memory Access Mapper

This block sits between a host byte port that addresses the legacy video window and a 32-bit synchronous video RAM. Every host byte read or write is first moved by a bank offset. The offset comes from an extended bank register. The moved address is then translated into a RAM word address and byte lane under one of three access modes. The mode is chosen by two control bits that normally come from the sequencer and graphics registers:

- **Linear byte mode (chain-4):** one host byte maps to one RAM byte.
- **Interleaved mode (odd/even):** even and odd host bytes go to different planes.
- **Planar mode:** one host address selects a whole 32-bit word, and a 32-bit latch is loaded on reads.

The address that each mode produces is compared with the configured video RAM size after that mode's own arithmetic. This closes the gap in which a bank value that is safe for one mode becomes unsafe when the mode changes later. An out-of-range read returns 0xFF. An out-of-range write never reaches the RAM.

The RAM port is driven combinationally in the cycle the request is sampled. Read data comes back through a two-stage return path.

Top module: `banked_vram_mapper`

## Requirements
- R1: A bank write stores `bank_wdata & BANK_MASK` (default mask 4'h3), whatever the access mode. The bank offset is that stored value shifted left by 16.
- R2: When `seq_chain4` is 1, the access uses linear byte addressing, whatever `gfx_oddeven` is: RAM word = byte address >> 2, lane = byte address[1:0]. Otherwise, when `gfx_oddeven` is 1, the access is interleaved. Otherwise it is planar.
- R3: A linear-mode write enables exactly one byte lane, lane a[1:0]. It happens only if `seq_plane_wmask[a[1:0]]` is 1; otherwise no RAM cycle is issued.
- R4: An interleaved read uses plane = {gfx_read_plane[1], a[0]} and RAM byte address = {a[top:1], plane[1:0]}. This equals ((a & ~1) << 1) | plane.
- R5: An interleaved write uses plane = {0, a[0]} with the same byte address formula. It happens only if `seq_plane_wmask[a[0]]` is 1.
- R6: In planar mode the RAM word index equals a. A write drives the data byte on all four lanes with `ram_be = seq_plane_wmask`, so lanes whose mask bit is 0 keep their old value. A read returns lane `gfx_read_plane` of the word. Byte lane i is `ram_wdata/ram_rdata[8i+7:8i]`, enabled by `ram_be[i]`.
- R7: The RAM byte address is a in linear mode, the R4/R5 address in interleaved mode, and a*4 in planar mode. When it is at or beyond `VRAM_BYTES`, a read returns 8'hFF and a write issues no RAM cycle.
- R8: Only an in-range planar read loads the returned 32-bit word into `latch_q`. Every other access leaves `latch_q` unchanged.
- R9: A read request sampled at clock edge t yields `host_rvalid` = 1 and `host_rdata` for exactly the cycle after edge t+1. A write produces no `host_rvalid`.
- R10: The bank offset is added to the window address before the mode translation and before the range check (a = host_addr + offset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host byte access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | WIN_AW | Window-relative byte address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte |
| host_rvalid | output | 1 | Read data valid pulse |
| seq_chain4 | input | 1 | Linear byte mode select |
| gfx_oddeven | input | 1 | Interleaved mode select |
| gfx_read_plane | input | 2 | Read plane select |
| seq_plane_wmask | input | 4 | Plane write mask |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | BANK_W | Bank register write value |
| ram_en | output | 1 | RAM cycle enable |
| ram_we | output | 1 | RAM write |
| ram_addr | output | RAM_AW | RAM word address |
| ram_be | output | 4 | RAM byte enables |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one edge after the cycle |
| latch_q | output | 32 | Planar read latch |

## Verification
The hardest situation to reach is a bank value that is in range for linear mode but out of range after the interleaved or planar arithmetic. Two examples are bank 1 with window address 0x8000 in interleaved mode, and bank 1 at address 0 in planar mode. The bench reaches it by setting the bank once and then switching modes between accesses, without rewriting the bank. Dropped writes are confirmed by counting RAM write cycles at the port. Latch retention is confirmed by reading `latch_q` directly after an out-of-range planar read.

// File: rtl/vram_map_pkg.sv
package vram_map_pkg;

  localparam int XAW = 40;
  typedef logic [XAW-1:0] xaddr_t;

  typedef enum logic [1:0] {
    AM_PLANAR     = 2'd0,
    AM_INTERLEAVE = 2'd1,
    AM_LINEAR     = 2'd2
  } acc_mode_e;

  typedef struct packed {
    acc_mode_e  mode;
    logic       oor;
    logic       wr_ok;
    xaddr_t     word;
    logic [1:0] lane;
    logic [3:0] be;
  } xlate_t;

  // Linear byte mode has priority over interleaved, which has priority over planar.
  function automatic acc_mode_e pick_mode(input logic chain4, input logic oddeven);
    if (chain4)       return AM_LINEAR;
    else if (oddeven) return AM_INTERLEAVE;
    else              return AM_PLANAR;
  endfunction

  // Clear bit 0 of the address, shift left by one, then insert the two plane bits.
  function automatic xaddr_t interleave_byte(input xaddr_t a, input logic [1:0] plane);
    return {a[XAW-2:1], plane};
  endfunction

  function automatic logic beyond(input xaddr_t byte_addr, input xaddr_t size);
    return byte_addr >= size;
  endfunction

  function automatic logic [3:0] lane_onehot(input logic [1:0] l);
    return 4'b0001 << l;
  endfunction

endpackage

// File: rtl/vram_bank_reg.sv
module vram_bank_reg #(
  parameter int                BANK_W    = 4,
  parameter logic [BANK_W-1:0] BANK_MASK = 'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic [BANK_W-1:0] bank_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_we) bank_q <= bank_wdata & BANK_MASK;
  end

  // R1: the stored bank is always the masked write value
  a_r1_bank_masked: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> bank_q == ($past(bank_wdata) & BANK_MASK));

endmodule

// File: rtl/vram_addr_xlate.sv
module vram_addr_xlate
  import vram_map_pkg::*;
#(
  parameter int          WIN_AW     = 16,
  parameter int          BANK_W     = 4,
  parameter int unsigned VRAM_BYTES = 32'h30000
) (
  input  logic [WIN_AW-1:0] host_addr,
  input  logic              host_we,
  input  logic [BANK_W-1:0] bank,
  input  logic              chain4,
  input  logic              oddeven,
  input  logic [1:0]        read_plane,
  input  logic [3:0]        plane_wmask,
  output xlate_t            xl
);

  localparam xaddr_t SIZE_X = xaddr_t'(VRAM_BYTES);

  xaddr_t     eff;
  xaddr_t     byte_a;
  logic [1:0] plane_rd;
  logic [1:0] plane_wr;

  always_comb begin
    // R10: the bank offset is added first; translation and range check follow
    eff      = xaddr_t'(host_addr) + (xaddr_t'(bank) << 16);
    plane_rd = {read_plane[1], eff[0]};
    plane_wr = {1'b0, eff[0]};
    xl       = '0;
    xl.mode  = pick_mode(chain4, oddeven);
    case (xl.mode)
      AM_LINEAR: begin
        byte_a   = eff;
        xl.word  = eff >> 2;
        xl.lane  = eff[1:0];
        xl.wr_ok = plane_wmask[eff[1:0]];
        xl.be    = lane_onehot(eff[1:0]);
      end
      AM_INTERLEAVE: begin
        byte_a   = interleave_byte(eff, host_we ? plane_wr : plane_rd);
        xl.word  = byte_a >> 2;
        xl.lane  = byte_a[1:0];
        xl.wr_ok = plane_wmask[plane_wr];
        xl.be    = lane_onehot(byte_a[1:0]);
      end
      default: begin
        byte_a   = eff << 2;
        xl.word  = eff;
        xl.lane  = read_plane;
        xl.wr_ok = |plane_wmask;
        xl.be    = plane_wmask;
      end
    endcase
    xl.oor = beyond(byte_a, SIZE_X);
  end

endmodule

// File: rtl/vram_read_return.sv
module vram_read_return (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue_rd,
  input  logic        issue_oor,
  input  logic        issue_planar,
  input  logic [1:0]  issue_lane,
  input  logic [31:0] ram_rdata,
  output logic [7:0]  rdata,
  output logic        rvalid,
  output logic [31:0] latch_q,
  output logic        latch_load
);

  logic       p_rd, p_oor, p_planar;
  logic [1:0] p_lane;
  logic [7:0] lane_byte [4];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane_byte[g] = ram_rdata[8*g +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rd     <= 1'b0;
      p_oor    <= 1'b0;
      p_planar <= 1'b0;
      p_lane   <= '0;
    end else begin
      p_rd     <= issue_rd;
      p_oor    <= issue_oor;
      p_planar <= issue_planar;
      p_lane   <= issue_lane;
    end
  end

  assign latch_load = p_rd & p_planar & ~p_oor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid  <= 1'b0;
      rdata   <= '0;
      latch_q <= '0;
    end else begin
      rvalid <= p_rd;
      if (p_rd) rdata <= p_oor ? 8'hFF : lane_byte[p_lane];
      if (latch_load) latch_q <= ram_rdata;
    end
  end

  // R7: an out-of-range read returns all ones
  a_r7_oor_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rd && p_oor) |=> rdata == 8'hFF);
  // R8: the latch moves only on an in-range planar read
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_load |=> $stable(latch_q));
  // R9: read data is valid two edges after the request
  a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    issue_rd |-> ##2 rvalid);

endmodule

// File: rtl/banked_vram_mapper.sv
module banked_vram_mapper
  import vram_map_pkg::*;
#(
  parameter int                WIN_AW     = 16,
  parameter int                BANK_W     = 4,
  parameter logic [BANK_W-1:0] BANK_MASK  = 'h3,
  parameter int unsigned       VRAM_BYTES = 32'h30000,
  localparam int               RAM_AW     = $clog2(VRAM_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [WIN_AW-1:0] host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              host_rvalid,
  input  logic              seq_chain4,
  input  logic              gfx_oddeven,
  input  logic [1:0]        gfx_read_plane,
  input  logic [3:0]        seq_plane_wmask,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_wdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [3:0]        ram_be,
  output logic [31:0]       ram_wdata,
  input  logic [31:0]       ram_rdata,
  output logic [31:0]       latch_q
);

  logic [BANK_W-1:0] bank_q;
  xlate_t            xl;
  logic              issue_rd;
  logic              latch_load;
  logic              unused_hi;

  vram_bank_reg #(.BANK_W(BANK_W), .BANK_MASK(BANK_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_wdata(bank_wdata), .bank_q(bank_q)
  );

  vram_addr_xlate #(.WIN_AW(WIN_AW), .BANK_W(BANK_W), .VRAM_BYTES(VRAM_BYTES)) u_xlate (
    .host_addr(host_addr), .host_we(host_we), .bank(bank_q),
    .chain4(seq_chain4), .oddeven(gfx_oddeven), .read_plane(gfx_read_plane),
    .plane_wmask(seq_plane_wmask), .xl(xl)
  );

  assign ram_en    = host_req & ~xl.oor & (~host_we | xl.wr_ok);
  assign ram_we    = ram_en & host_we;
  assign ram_addr  = xl.word[RAM_AW-1:0];
  assign unused_hi = ^xl.word[XAW-1:RAM_AW];
  assign ram_be    = host_we ? xl.be : 4'hF;
  assign ram_wdata = {4{host_wdata}};
  assign issue_rd  = host_req & ~host_we;

  vram_read_return u_ret (
    .clk(clk), .rst_n(rst_n), .issue_rd(issue_rd), .issue_oor(xl.oor),
    .issue_planar(xl.mode == AM_PLANAR), .issue_lane(xl.lane),
    .ram_rdata(ram_rdata), .rdata(host_rdata), .rvalid(host_rvalid),
    .latch_q(latch_q), .latch_load(latch_load)
  );

  // R3: a linear-mode write touches exactly one byte lane
  a_r3_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && seq_chain4) |-> $countones(ram_be) == 1);
  // R6: planar writes carry the same byte on every lane
  a_r6_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !seq_chain4 && !gfx_oddeven) |->
      (ram_wdata[31:24] == host_wdata && ram_wdata[15:8] == ram_wdata[7:0]));
  // R9: a write never yields read data
  a_r9_no_rvalid_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we) |-> ##2 !host_rvalid);

endmodule

// File: tb/test_banked_vram_mapper.sv
`timescale 1ns/1ps
module test_banked_vram_mapper;

  localparam int          WIN_AW     = 16;
  localparam int          BANK_W     = 4;
  localparam int unsigned VRAM_BYTES = 32'h30000;
  localparam int          RAM_AW     = $clog2(VRAM_BYTES / 4);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              host_req = 0, host_we = 0;
  logic [WIN_AW-1:0] host_addr = '0;
  logic [7:0]        host_wdata = '0, host_rdata;
  logic              host_rvalid;
  logic              seq_chain4 = 0, gfx_oddeven = 0;
  logic [1:0]        gfx_read_plane = '0;
  logic [3:0]        seq_plane_wmask = '0;
  logic              bank_we = 0;
  logic [BANK_W-1:0] bank_wdata = '0;
  logic              ram_en, ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [3:0]        ram_be;
  logic [31:0]       ram_wdata, ram_rdata = '0, latch_q;

  banked_vram_mapper #(.WIN_AW(WIN_AW), .BANK_W(BANK_W), .BANK_MASK(4'h3),
                       .VRAM_BYTES(VRAM_BYTES)) i_banked_vram_mapper (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .seq_chain4(seq_chain4), .gfx_oddeven(gfx_oddeven),
    .gfx_read_plane(gfx_read_plane), .seq_plane_wmask(seq_plane_wmask),
    .bank_we(bank_we), .bank_wdata(bank_wdata), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_be(ram_be), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .latch_q(latch_q)
  );

  // Sparse RAM model with byte enables, one-edge read latency
  logic [31:0] mem [int unsigned];
  int          wr_cnt = 0;
  always @(posedge clk) begin
    logic [31:0] w;
    if (ram_en) begin
      w = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 32'h0;
      if (ram_we) begin
        for (int i = 0; i < 4; i++) if (ram_be[i]) w[8*i +: 8] = ram_wdata[8*i +: 8];
        mem[int'(ram_addr)] = w;
        wr_cnt <= wr_cnt + 1;
      end else begin
        ram_rdata <= w;
      end
    end
  end

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode[1] = linear byte select, mode[0] = interleave select
  task automatic access(input logic [1:0] mode, input logic we, input logic [1:0] rps,
                        input logic [3:0] wm, input logic [15:0] a, input logic [7:0] wd,
                        output logic [7:0] rd, output logic rv);
    @(negedge clk);
    seq_chain4 = mode[1]; gfx_oddeven = mode[0]; gfx_read_plane = rps;
    seq_plane_wmask = wm; host_addr = a; host_wdata = wd; host_we = we; host_req = 1;
    @(negedge clk);
    host_req = 0;
    @(negedge clk);
    rd = host_rdata; rv = host_rvalid;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] mode, input logic [1:0] rps,
                        input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d; logic v;
    access(mode, 1'b0, rps, 4'h0, a, 8'h00, d, v);
    chk({tag, " rvalid"}, {31'b0, v}, 32'h1);
    chk(tag, {24'b0, d}, {24'b0, exp});
  endtask

  task automatic wr(input logic [1:0] mode, input logic [3:0] wm,
                    input logic [15:0] a, input logic [7:0] wd);
    logic [7:0] d; logic v;
    access(mode, 1'b1, 2'd0, wm, a, wd, d, v);
  endtask

  task automatic set_bank(input logic [3:0] v);
    @(negedge clk); bank_we = 1; bank_wdata = v;
    @(negedge clk); bank_we = 0;
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic        we;
    logic [1:0]  rps;
    logic [3:0]  wm;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 1'b1, 2'd0, 4'hF, 16'h0005, 8'hA5, 8'h00, 4'd2},  // R2 linear write
    '{2'd2, 1'b0, 2'd0, 4'h0, 16'h0005, 8'h00, 8'hA5, 4'd2},  // R2 linear read
    '{2'd2, 1'b1, 2'd0, 4'hB, 16'h0006, 8'h3C, 8'h00, 4'd3},  // R3 lane 2 masked off
    '{2'd2, 1'b0, 2'd0, 4'h0, 16'h0006, 8'h00, 8'h00, 4'd3},  // R3 nothing written
    '{2'd0, 1'b0, 2'd1, 4'h0, 16'h0001, 8'h00, 8'hA5, 4'd6},  // R6 word 1 lane 1
    '{2'd0, 1'b1, 2'd0, 4'h5, 16'h0002, 8'h77, 8'h00, 4'd6},  // R6 lanes 0,2
    '{2'd0, 1'b0, 2'd2, 4'h0, 16'h0002, 8'h00, 8'h77, 4'd6},  // R6
    '{2'd0, 1'b0, 2'd1, 4'h0, 16'h0002, 8'h00, 8'h00, 4'd6},  // R6 lane kept
    '{2'd1, 1'b1, 2'd0, 4'h2, 16'h0011, 8'h42, 8'h00, 4'd5},  // R5 -> byte 0x21
    '{2'd1, 1'b0, 2'd0, 4'h0, 16'h0011, 8'h00, 8'h42, 4'd4},  // R4 plane 1
    '{2'd2, 1'b0, 2'd0, 4'h0, 16'h0021, 8'h00, 8'h42, 4'd4},  // R4 cross check
    '{2'd1, 1'b0, 2'd2, 4'h0, 16'h0011, 8'h00, 8'h00, 4'd4},  // R4 plane 3
    '{2'd1, 1'b1, 2'd0, 4'h1, 16'h0013, 8'h55, 8'h00, 4'd5},  // R5 plane 1 masked
    '{2'd2, 1'b0, 2'd0, 4'h0, 16'h0025, 8'h00, 8'h00, 4'd5},  // R5 not written
    '{2'd1, 1'b1, 2'd0, 4'h1, 16'h0012, 8'h66, 8'h00, 4'd5},  // R5 plane 0 -> 0x24
    '{2'd2, 1'b0, 2'd0, 4'h0, 16'h0024, 8'h00, 8'h66, 4'd5},  // R5
    '{2'd3, 1'b0, 2'd0, 4'h0, 16'h0021, 8'h00, 8'h42, 4'd2}   // R2 linear wins
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d; logic v; int w0;
    repeat (3) @(negedge clk);
    chk("R9 reset rvalid", {31'b0, host_rvalid}, 32'h0);
    chk("R8 reset latch", latch_q, 32'h0);
    chk("R7 idle ram_en", {31'b0, ram_en}, 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].mode, VEC[i].we, VEC[i].rps, VEC[i].wm, VEC[i].addr, VEC[i].wd, d, v);
      if (VEC[i].we) begin
        chk($sformatf("R9 vec%0d R%0d write rvalid", i, VEC[i].req), {31'b0, v}, 32'h0);
      end else begin
        chk($sformatf("R9 vec%0d R%0d rvalid", i, VEC[i].req), {31'b0, v}, 32'h1);
        chk($sformatf("vec%0d R%0d rdata", i, VEC[i].req), {24'b0, d}, {24'b0, VEC[i].exp});
      end
    end
    chk("R8 latch after planar read", latch_q, 32'h0077_0077);

    // R7 / R8 planar range boundary
    rd_chk("R7 planar oor read", 2'd0, 2'd0, 16'hC000, 8'hFF);
    chk("R8 latch kept on oor", latch_q, 32'h0077_0077);
    rd_chk("R7 planar last word", 2'd0, 2'd0, 16'hBFFF, 8'h00);
    chk("R8 latch loaded", latch_q, 32'h0);

    // dropped writes seen as absent RAM write cycles
    w0 = wr_cnt;
    wr(2'd0, 4'hF, 16'hC000, 8'hEE);
    chk("R7 oor write dropped", wr_cnt, w0);
    wr(2'd2, 4'hE, 16'h0000, 8'h12);
    chk("R3 masked linear write", wr_cnt, w0);
    wr(2'd1, 4'h1, 16'h0001, 8'h34);
    chk("R5 masked interleave write", wr_cnt, w0);

    // bank offset
    set_bank(4'h5);
    wr(2'd2, 4'hF, 16'h0010, 8'h99);
    chk("R1 banked write issued", wr_cnt, w0 + 1);
    set_bank(4'h0);
    rd_chk("R10 bank 0 differs", 2'd2, 2'd0, 16'h0010, 8'h00);
    set_bank(4'h5);
    rd_chk("R1 bank 5 masked to 1", 2'd2, 2'd0, 16'h0010, 8'h99);
    set_bank(4'h6);
    wr(2'd2, 4'hF, 16'hFFFF, 8'h11);
    rd_chk("R1 R7 last in-range byte", 2'd2, 2'd0, 16'hFFFF, 8'h11);
    set_bank(4'h7);
    rd_chk("R7 linear at size", 2'd2, 2'd0, 16'h0000, 8'hFF);

    // bank chosen first, mode changed afterwards
    set_bank(4'h1);
    rd_chk("R10 interleave oor after bank", 2'd1, 2'd0, 16'h8000, 8'hFF);
    wr(2'd1, 4'h2, 16'h7FFF, 8'h5A);
    rd_chk("R4 interleave top in range", 2'd1, 2'd0, 16'h7FFF, 8'h5A);
    rd_chk("R10 planar oor after bank", 2'd0, 2'd0, 16'h0000, 8'hFF);
    set_bank(4'h0);

    // R9 exact timing
    @(negedge clk);
    seq_chain4 = 1; gfx_oddeven = 0; host_addr = 16'h0005; host_we = 0; host_req = 1;
    @(negedge clk); host_req = 0;
    chk("R9 not early", {31'b0, host_rvalid}, 32'h0);
    @(negedge clk);
    chk("R9 valid", {31'b0, host_rvalid}, 32'h1);
    chk("R9 data", {24'b0, host_rdata}, 32'hA5);
    @(negedge clk);
    chk("R9 single pulse", {31'b0, host_rvalid}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule